// File: doc/BRIEF.md
# Token-Passing Transmit Handshake Sequencer

This block is the control machine on the transmit side of a node on a token-passing network. The host places a packet and its destination address in the node's buffer and then issues a transmit command. The sequencer holds that request until the node next receives the token. At that point it first asks the destination whether a receive buffer is free. A positive reply lets the packet go out, followed by its 16-bit check word. A negative reply, or no reply at all, sends the token on to the next node and keeps the request for the next visit.

After the check word the sequencer waits for a final reply. A positive reply records a successful delivery. A negative reply, or silence until the response timeout, records a failure. In both cases the request is finished and the token is passed on. Two status bits report the outcome. The interrupt line is the OR of those status bits, each gated by a host mask bit.

The line coder, the CRC datapath and the buffer memory sit outside this block. The sequencer reaches them through a message request with a kind code and a done strobe. Received replies arrive as one-cycle acknowledge and negative-acknowledge strobes.

Top module: `tx_seq_top`

## Requirements
- R1: After reset, status is 2'b01: bit 0 (transmitter available) is 1 and bit 1 (delivery acknowledged) is 0. msg_req is 0.
- R2: When status bit 0 is 1, a cmd_tx_en pulse clears status bits 0 and 1 and latches dest_id onto msg_dest. When status bit 0 is 0, cmd_tx_en has no effect, and msg_dest and status keep their values.
- R3: On a token_in pulse with no request pending (status bit 0 = 1), the next cycle requests msg_kind 4 (token pass). msg_req drops in the cycle after msg_done.
- R4: On a token_in pulse with a request pending, the next cycle requests msg_kind 1 (free-buffer enquiry), with msg_dest holding the latched destination.
- R5: An rx_ack while the sequencer waits for the enquiry reply leads to a request of msg_kind 2 (data). After its msg_done comes msg_kind 3 (check word).
- R6: An rx_nak while the sequencer waits for the enquiry reply leads to msg_kind 4 with no data. Status stays 2'b00, and the next token_in starts a new enquiry.
- R7: If neither reply arrives within TIMEOUT cycles of the enquiry's msg_done, the sequencer requests msg_kind 4. The request stays pending (status 2'b00), and msg_req stays 0 for the first TIMEOUT-1 of those cycles.
- R8: An rx_ack after the check word sets status to 2'b11 in the next cycle, alongside a request of msg_kind 4.
- R9: An rx_nak, or no reply within TIMEOUT cycles, after the check word sets status to 2'b01, alongside a request of msg_kind 4.
- R10: irq is 1 exactly when some status bit and the irq_mask bit at the same position are both 1. irq is a level and follows the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_tx_en | input | 1 | Host transmit command strobe |
| dest_id | input | ID_W | Destination address from the buffer, sampled on an accepted command |
| token_in | input | 1 | Token received strobe |
| msg_done | input | 1 | Line layer has finished the requested message |
| rx_ack | input | 1 | Acknowledge received strobe |
| rx_nak | input | 1 | Negative acknowledge received strobe |
| irq_mask | input | 2 | Interrupt enable per status bit |
| msg_req | output | 1 | Message send request |
| msg_kind | output | 3 | 1 enquiry, 2 data, 3 check word, 4 token pass |
| msg_dest | output | ID_W | Latched destination address |
| status | output | 2 | Bit 0 transmitter available, bit 1 delivery acknowledged |
| irq | output | 1 | Masked interrupt level |

## Verification
A wrong sequencer state shows up at the ports within one cycle, as the wrong msg_kind or as a request that appears or drops at the wrong moment. A miscounting timeout timer shows as a token pass that comes too early or too late, and the bench brackets it on both sides. A status update that is lost or misplaced shows in the cycle after the final reply: transmitter-available and acknowledged take the wrong values, a late command is wrongly accepted, or the gated interrupt level is wrong.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [2:0] {
    MSG_NONE  = 3'd0,
    MSG_ENQ   = 3'd1,
    MSG_DATA  = 3'd2,
    MSG_CRC   = 3'd3,
    MSG_TOKEN = 3'd4
  } msg_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ENQ,
    S_WAIT_REPLY,
    S_DATA,
    S_CRC,
    S_WAIT_FINAL,
    S_PASS
  } seq_state_e;

  localparam int STAT_W     = 2;
  localparam int STAT_AVAIL = 0;
  localparam int STAT_ACKED = 1;

endpackage

// File: rtl/tx_seq_timer.sv
module tx_seq_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (run && !expired);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == LIMIT);

endmodule

// File: rtl/tx_seq_status.sv
module tx_seq_status
  import tx_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_tx_en,
  input  logic              done_ok,
  input  logic              done_fail,
  input  logic [STAT_W-1:0] irq_mask,
  output logic              accept,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  logic avail_q, avail_d;
  logic acked_q, acked_d;
  logic stat_en;
  logic [STAT_W-1:0] gated;

  assign accept  = cmd_tx_en && avail_q;
  assign stat_en = accept || done_ok || done_fail;

  always_comb begin
    avail_d = avail_q;
    acked_d = acked_q;
    if (done_ok || done_fail) begin
      avail_d = 1'b1;
      acked_d = done_ok;
    end else if (accept) begin
      avail_d = 1'b0;
      acked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b1;
      acked_q <= 1'b0;
    end else if (stat_en) begin
      avail_q <= avail_d;
      acked_q <= acked_d;
    end
  end

  always_comb begin
    status             = '0;
    status[STAT_AVAIL] = avail_q;
    status[STAT_ACKED] = acked_q;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_gate
    assign gated[i] = status[i] & irq_mask[i];
  end

  assign irq = |gated;

endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pending,
  input  logic       token_in,
  input  logic       msg_done,
  input  logic       rx_ack,
  input  logic       rx_nak,
  input  logic       timeout,
  output logic       msg_req,
  output logic [2:0] msg_kind,
  output logic       timer_start,
  output logic       timer_run,
  output logic       done_ok,
  output logic       done_fail
);

  seq_state_e state_q, state_d;
  msg_kind_e  kind;

  always_comb begin
    state_d   = state_q;
    done_ok   = 1'b0;
    done_fail = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (token_in) state_d = pending ? S_ENQ : S_PASS;
      end
      S_ENQ: begin
        if (msg_done) state_d = S_WAIT_REPLY;
      end
      S_WAIT_REPLY: begin
        if (rx_ack)                 state_d = S_DATA;
        else if (rx_nak || timeout) state_d = S_PASS;
      end
      S_DATA: begin
        if (msg_done) state_d = S_CRC;
      end
      S_CRC: begin
        if (msg_done) state_d = S_WAIT_FINAL;
      end
      S_WAIT_FINAL: begin
        if (rx_ack) begin
          done_ok = 1'b1;
          state_d = S_PASS;
        end else if (rx_nak || timeout) begin
          done_fail = 1'b1;
          state_d   = S_PASS;
        end
      end
      S_PASS: begin
        if (msg_done) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_ENQ:   kind = MSG_ENQ;
      S_DATA:  kind = MSG_DATA;
      S_CRC:   kind = MSG_CRC;
      S_PASS:  kind = MSG_TOKEN;
      default: kind = MSG_NONE;
    endcase
  end

  assign msg_kind    = kind;
  assign msg_req     = (kind != MSG_NONE);
  assign timer_start = msg_done && ((state_q == S_ENQ) || (state_q == S_CRC));
  assign timer_run   = (state_q == S_WAIT_REPLY) || (state_q == S_WAIT_FINAL);

endmodule

// File: rtl/tx_seq_top.sv
module tx_seq_top
  import tx_seq_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int TIMEOUT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_tx_en,
  input  logic [ID_W-1:0] dest_id,
  input  logic            token_in,
  input  logic            msg_done,
  input  logic            rx_ack,
  input  logic            rx_nak,
  input  logic [1:0]      irq_mask,
  output logic            msg_req,
  output logic [2:0]      msg_kind,
  output logic [ID_W-1:0] msg_dest,
  output logic [1:0]      status,
  output logic            irq
);

  logic accept;
  logic done_ok, done_fail;
  logic timer_start, timer_run, timeout;
  logic [ID_W-1:0] dest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (accept) begin
      dest_q <= dest_id;
    end
  end

  assign msg_dest = dest_q;

  tx_seq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_tx_en (cmd_tx_en),
    .done_ok   (done_ok),
    .done_fail (done_fail),
    .irq_mask  (irq_mask),
    .accept    (accept),
    .status    (status),
    .irq       (irq)
  );

  tx_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (!status[STAT_AVAIL]),
    .token_in    (token_in),
    .msg_done    (msg_done),
    .rx_ack      (rx_ack),
    .rx_nak      (rx_nak),
    .timeout     (timeout),
    .msg_req     (msg_req),
    .msg_kind    (msg_kind),
    .timer_start (timer_start),
    .timer_run   (timer_run),
    .done_ok     (done_ok),
    .done_fail   (done_fail)
  );

  tx_seq_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (timer_start),
    .run     (timer_run),
    .expired (timeout)
  );

endmodule

// File: rtl/tx_seq_check.sv
module tx_seq_check #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_tx_en,
  input logic            rx_ack,
  input logic [1:0]      irq_mask,
  input logic            msg_req,
  input logic [2:0]      msg_kind,
  input logic [ID_W-1:0] msg_dest,
  input logic [1:0]      status,
  input logic            irq
);

  assert_kind_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msg_kind >= 3'd1 && msg_kind <= 3'd4));

  assert_cmd_clears_avail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_en && status[0]) |=> !status[0]);

  assert_dest_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && $past(!status[0])) |-> $stable(msg_dest));

  assert_data_only_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && (msg_kind == 3'd2 || msg_kind == 3'd3)) |-> !status[0]);

  assert_acked_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(rx_ack));

  assert_finish_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (msg_req && msg_kind == 3'd4));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|irq_mask));

endmodule

bind tx_seq_top tx_seq_check #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_tx_en (cmd_tx_en),
  .rx_ack    (rx_ack),
  .irq_mask  (irq_mask),
  .msg_req   (msg_req),
  .msg_kind  (msg_kind),
  .msg_dest  (msg_dest),
  .status    (status),
  .irq       (irq)
);

// File: tb/tx_seq_top_test.sv
module tx_seq_top_test;

  localparam int ID_W = 8;
  localparam int TMO  = 12;

  logic            clk;
  logic            rst_n;
  logic            cmd_tx_en;
  logic [ID_W-1:0] dest_id;
  logic            token_in;
  logic            msg_done;
  logic            rx_ack;
  logic            rx_nak;
  logic [1:0]      irq_mask;
  logic            msg_req;
  logic [2:0]      msg_kind;
  logic [ID_W-1:0] msg_dest;
  logic [1:0]      status;
  logic            irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // rows: [6:5] final reply (0 ack, 1 nak, 2 silent), [4:3] mask,
  //       [2] exp avail, [1] exp acked, [0] exp irq
  localparam logic [6:0] VEC [6] = '{
    {2'd0, 2'b01, 1'b1, 1'b1, 1'b1},
    {2'd0, 2'b10, 1'b1, 1'b1, 1'b1},
    {2'd0, 2'b00, 1'b1, 1'b1, 1'b0},
    {2'd1, 2'b10, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b10, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b01, 1'b1, 1'b0, 1'b1}
  };

  tx_seq_top #(.ID_W(ID_W), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_tx_en(cmd_tx_en), .dest_id(dest_id),
    .token_in(token_in), .msg_done(msg_done), .rx_ack(rx_ack), .rx_nak(rx_nak),
    .irq_mask(irq_mask), .msg_req(msg_req), .msg_kind(msg_kind),
    .msg_dest(msg_dest), .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic expect_msg(input logic [2:0] k, input string tag);
    chk(tag, {12'd0, msg_req, msg_kind}, {12'd0, 1'b1, k});
    msg_done = 1'b1;
    step();
    msg_done = 1'b0;
  endtask

  task automatic pulse_cmd(input logic [ID_W-1:0] d);
    cmd_tx_en = 1'b1;
    dest_id   = d;
    step();
    cmd_tx_en = 1'b0;
  endtask

  task automatic pulse_token();
    token_in = 1'b1;
    step();
    token_in = 1'b0;
  endtask

  task automatic reply(input logic [1:0] code);
    if (code == 2'd0) begin
      rx_ack = 1'b1; step(); rx_ack = 1'b0;
    end else if (code == 2'd1) begin
      rx_nak = 1'b1; step(); rx_nak = 1'b0;
    end else begin
      repeat (TMO) step();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_tx_en = 1'b0; dest_id = '0; token_in = 1'b0;
    msg_done = 1'b0; rx_ack = 1'b0; rx_nak = 1'b0; irq_mask = 2'b01;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 status", {14'd0, status}, 16'h0001);
    chk("R1 msg_req", {15'd0, msg_req}, 16'd0);
    chk("R10 irq avail masked in", {15'd0, irq}, 16'd1);
    irq_mask = 2'b00;
    step();
    chk("R10 irq masked out", {15'd0, irq}, 16'd0);

    // R3 token with nothing pending
    pulse_token();
    expect_msg(3'd4, "R3 idle token pass");
    chk("R3 request drops", {15'd0, msg_req}, 16'd0);

    // R2 accept, then ignore while busy
    pulse_cmd(8'h5A);
    chk("R2 status after cmd", {14'd0, status}, 16'h0000);
    pulse_cmd(8'hA5);
    chk("R2 late cmd dest kept", {8'd0, msg_dest}, 16'h005A);
    chk("R2 late cmd status kept", {14'd0, status}, 16'h0000);

    // R4 enquiry, R6 negative reply
    pulse_token();
    chk("R4 enquiry dest", {8'd0, msg_dest}, 16'h005A);
    expect_msg(3'd1, "R4 enquiry");
    reply(2'd1);
    expect_msg(3'd4, "R6 pass after nak");
    chk("R6 still pending", {14'd0, status}, 16'h0000);

    // R6 retry, R7 timeout
    pulse_token();
    expect_msg(3'd1, "R6 retry enquiry");
    repeat (TMO - 1) step();
    chk("R7 no early pass", {15'd0, msg_req}, 16'd0);
    step();
    expect_msg(3'd4, "R7 pass on timeout");
    chk("R7 still pending", {14'd0, status}, 16'h0000);

    // R5 data and check word, R8 final ack
    pulse_token();
    expect_msg(3'd1, "R5 enquiry");
    reply(2'd0);
    expect_msg(3'd2, "R5 data");
    expect_msg(3'd3, "R5 check word");
    chk("R8 waiting status", {14'd0, status}, 16'h0000);
    reply(2'd0);
    chk("R8 status acked", {14'd0, status}, 16'h0003);
    expect_msg(3'd4, "R8 pass after delivery");

    // vector table: final outcome vs mask (R8 R9 R10)
    foreach (VEC[i]) begin
      irq_mask = VEC[i][4:3];
      pulse_cmd(8'(i + 1));
      chk("R2 cmd clears status", {14'd0, status}, 16'h0000);
      chk("R10 irq while busy", {15'd0, irq}, 16'd0);
      pulse_token();
      expect_msg(3'd1, "R4 table enquiry");
      chk("R4 table dest", {8'd0, msg_dest}, 16'(i + 1));
      reply(2'd0);
      expect_msg(3'd2, "R5 table data");
      expect_msg(3'd3, "R5 table check word");
      reply(VEC[i][6:5]);
      chk("R9 table status", {14'd0, status}, {14'd0, VEC[i][1], VEC[i][2]});
      chk("R10 table irq", {15'd0, irq}, {15'd0, VEC[i][0]});
      expect_msg(3'd4, "R9 table pass");
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule